// File: doc/BRIEF.md
# SPI Status-Register Write Guard

This block is the slave-side command front end of a serial memory that owns the protection bits of its status register. The clock, chip-select, serial input and write-protect pins are brought into the system clock domain through a small synchronizer. Edges of the serial clock are detected there. An eight-bit opcode is shifted in most significant bit first, sampled on rising serial-clock edges, which works for both SPI mode 0 and mode 3. Two opcodes modify the register: an arming opcode, followed by a write opcode that carries one data byte. A third opcode streams the register back out on the serial output.

A write only reaches the register when all of the following hold. The write is the very next instruction after the arming opcode. Its frame length is exact. The register is not locked against the write-protect pin. Nothing changes until chip-select rises. The controller is a state machine with five states. `ST_IDLE` is left for `ST_OPCODE` when chip-select falls. `ST_OPCODE` moves on the eighth rising edge: to `ST_WDATA` for the write opcode, to `ST_READ` for the read opcode, and to `ST_TAIL` for anything else. `ST_WDATA` moves to `ST_TAIL` on its sixteenth rising edge. From every active state, a rising chip-select returns the machine to `ST_IDLE` and issues one event to the register stage: arm, write, keep or cancel.

Top module: `spi_status_guard`

## Requirements
- R1: Opcode 0x50, received MSB first with exactly 8 rising serial-clock edges before chip-select rises, leaves a pending write enable.
- R2: A write (opcode 0x01 plus one data byte) changes the register only when the instruction just before it was an arming instruction. Any other intervening instruction, for example 0x06, cancels the pending enable.
- R3: The register is updated only when chip-select rises at the end of a valid write. Until then, the value shifted in has no effect on the register.
- R4: When the write-protect pin is low and the lock bit is 1, a write leaves all register bits unchanged.
- R5: While the write-protect pin is low, the lock bit may go from 0 to 1 but never from 1 to 0.
- R6: With the write-protect pin high, the lock bit and both protect bits are freely writable, including clearing the lock bit.
- R7: With the lock bit at 0 and the pin low, one write sets the lock bit and both protect bits together.
- R8: The serial-output enable stays low during arming and write instructions.
- R9: Opcode 0x05 drives the register on the serial output, MSB first, changing on falling serial-clock edges. It repeats the same byte for as long as clocks continue.
- R10: A read-status instruction placed between the arming and write instructions does not clear the pending enable.
- R11: If chip-select rises at a count other than 8 for arming or 16 for writing (too early or too late), the instruction is discarded and any pending enable is cleared.
- R12: Register layout: protect bit 0 at bit 2, protect bit 1 at bit 3, lock bit at bit 7. All other bits read 0 and ignore written ones. After reset the register is 0x00, no enable is pending and the output enable is low.
- R13: Every instruction behaves the same in SPI mode 0 (clock idles low) and mode 3 (clock idles high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip-select |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| miso | output | 1 | Serial data out, valid while `miso_oe` is high |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| status | output | 8 | Current register value for the array protection logic |

## Verification
A serial-clock edge at the pins reaches the controller after SYNC_STAGES system clocks. A new `miso` bit therefore appears SYNC_STAGES+1 cycles after a falling serial-clock edge. A committed write shows on `status` SYNC_STAGES+2 cycles after chip-select rises. The bench holds every serial-clock phase for eight system clocks. It samples `miso` at the next rising serial-clock edge, which is well past the update. It waits ten cycles after chip-select rises before reading `status`. The value is also confirmed through a read-status instruction, whose bytes a scoreboard compares in order.

// File: rtl/spi_sg_pkg.sv
package spi_sg_pkg;

    localparam logic [7:0] OP_ARM   = 8'h50;
    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h05;

    localparam int BIT_BP0  = 2;
    localparam int BIT_BP1  = 3;
    localparam int BIT_LOCK = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WDATA,
        ST_READ,
        ST_TAIL
    } sg_state_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ARM,
        EV_WRITE,
        EV_KEEP,
        EV_CANCEL
    } sg_event_t;

endpackage

// File: rtl/spi_sg_sync.sv
module spi_sg_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] ff_q;
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= RST_VAL[g];
                else        ff_q <= d_i[g];
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff_q <= {STAGES{RST_VAL[g]}};
                else        ff_q <= {ff_q[STAGES-2:0], d_i[g]};
            end
        end
        assign q_o[g] = ff_q[STAGES-1];
    end

endmodule

// File: rtl/spi_sg_ctrl.sv
module spi_sg_ctrl
    import spi_sg_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    input  logic [7:0] status_i,
    output sg_event_t  ev_o,
    output logic [2:0] wbits_o,
    output logic       miso_o,
    output logic       miso_oe_o
);

    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_OP_END = CNT_W'(7);
    localparam logic [CNT_W-1:0] CNT_WD_END = CNT_W'(15);
    localparam logic [CNT_W-1:0] CNT_ARM_OK = CNT_W'(8);
    localparam logic [CNT_W-1:0] CNT_WR_OK  = CNT_W'(16);

    sg_state_t        st_q, st_n;
    sg_event_t        ev_q, ev_n;
    logic             sck_d, cs_d;
    logic             sck_rise, sck_fall, cs_rise, cs_fall;
    logic [CNT_W-1:0] cnt_q, cnt_inc;
    logic [7:0]       sh_q, shifted, op_q, tx_q;
    logic             miso_q;

    // edge detection on synchronized pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;
    assign cs_fall  = ~cs_n_s & cs_d;
    assign shifted  = {sh_q[6:0], mosi_s};
    assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cs_fall) st_n = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (cs_rise) begin
                    st_n = ST_IDLE;
                end else if (sck_rise && cnt_q == CNT_OP_END) begin
                    if (shifted == OP_WRITE)     st_n = ST_WDATA;
                    else if (shifted == OP_READ) st_n = ST_READ;
                    else                         st_n = ST_TAIL;
                end
            end
            ST_WDATA: begin
                if (cs_rise)                                    st_n = ST_IDLE;
                else if (sck_rise && cnt_q == CNT_WD_END)       st_n = ST_TAIL;
            end
            ST_READ, ST_TAIL: begin
                if (cs_rise) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // event issued when chip-select closes an instruction
    always_comb begin
        ev_n = EV_NONE;
        if (cs_rise) begin
            unique case (st_q)
                ST_TAIL: begin
                    if (op_q == OP_ARM && cnt_q == CNT_ARM_OK)       ev_n = EV_ARM;
                    else if (op_q == OP_WRITE && cnt_q == CNT_WR_OK) ev_n = EV_WRITE;
                    else                                             ev_n = EV_CANCEL;
                end
                ST_READ:             ev_n = EV_KEEP;
                ST_OPCODE, ST_WDATA: ev_n = EV_CANCEL;
                default:             ev_n = EV_NONE;
            endcase
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q   <= EV_NONE;
            cnt_q  <= '0;
            sh_q   <= '0;
            op_q   <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else begin
            ev_q <= ev_n;
            if (st_q == ST_IDLE && cs_fall)
                cnt_q <= '0;
            else if (st_q != ST_IDLE && sck_rise)
                cnt_q <= cnt_inc;
            if (sck_rise && (st_q == ST_OPCODE || st_q == ST_WDATA))
                sh_q <= shifted;
            if (st_q == ST_OPCODE && sck_rise && cnt_q == CNT_OP_END) begin
                op_q <= shifted;
                if (shifted == OP_READ) tx_q <= status_i;
            end else if (st_q == ST_READ && sck_fall) begin
                miso_q <= tx_q[7];
                tx_q   <= {tx_q[6:0], tx_q[7]};
            end
        end
    end

    always_comb begin
        ev_o      = ev_q;
        wbits_o   = {sh_q[BIT_LOCK], sh_q[BIT_BP1], sh_q[BIT_BP0]};
        miso_o    = miso_q;
        miso_oe_o = (st_q == ST_READ);
    end

    // R1: arming only from an exact 8-clock arming opcode
    p_arm_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q == EV_ARM) |-> (op_q == OP_ARM && cnt_q == CNT_ARM_OK));

    // R11: a write event only from an exact 16-clock write frame
    p_write_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q == EV_WRITE) |-> (op_q == OP_WRITE && cnt_q == CNT_WR_OK));

    // R8: output enabled only for a decoded read opcode
    p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe_o |-> (op_q == OP_READ));

    // R10: a keep event comes only from a read-status instruction
    p_keep_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q == EV_KEEP) |-> (op_q == OP_READ));

endmodule

// File: rtl/spi_sg_status.sv
module spi_sg_status
    import spi_sg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sg_event_t  ev_i,
    input  logic [2:0] wbits_i,
    input  logic       wp_n_i,
    output logic [7:0] status_o
);

    logic lock_q, bp1_q, bp0_q, en_q;
    logic allow;

    assign allow = wp_n_i | ~lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            bp1_q  <= 1'b0;
            bp0_q  <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            unique case (ev_i)
                EV_ARM:    en_q <= 1'b1;
                EV_CANCEL: en_q <= 1'b0;
                EV_WRITE: begin
                    en_q <= 1'b0;
                    if (en_q && allow) {lock_q, bp1_q, bp0_q} <= wbits_i;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        status_o           = '0;
        status_o[BIT_LOCK] = lock_q;
        status_o[BIT_BP1]  = bp1_q;
        status_o[BIT_BP0]  = bp0_q;
    end

    // R1: the enable rises only after an arming event
    p_arm_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(ev_i == EV_ARM));

    // R2: a write without a pending enable changes nothing
    p_need_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_WRITE && !en_q) |=> $stable(status_o));

    // R3: the register moves only after a write event
    p_commit_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> $past(ev_i == EV_WRITE));

    // R4: locked with the pin low, writes are ignored
    p_locked_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == EV_WRITE && !wp_n_i && lock_q) |=> $stable(status_o));

    // R5: the lock bit can only clear with the pin high
    p_no_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(wp_n_i));

endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import spi_sg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       wp_n,
    output logic       miso,
    output logic       miso_oe,
    output logic [7:0] status
);

    localparam int PIN_W = 4;

    logic [PIN_W-1:0] pins_s;
    sg_event_t        ev;
    logic [2:0]       wbits;
    logic [7:0]       status_w;

    spi_sg_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wp_n, mosi, cs_n, sck}),
        .q_o   (pins_s)
    );

    spi_sg_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[0]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[2]),
        .status_i  (status_w),
        .ev_o      (ev),
        .wbits_o   (wbits),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    spi_sg_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .wbits_i  (wbits),
        .wp_n_i   (pins_s[3]),
        .status_o (status_w)
    );

    assign status = status_w;

endmodule

// File: tb/test_spi_status_guard.sv
`timescale 1ns/1ps
module test_spi_status_guard;

    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n, sck, cs_n, mosi, wp_n;
    logic       miso, miso_oe;
    logic [7:0] status;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         errors = 0;
    bit         done   = 0;
    logic [7:0] rx     = '0;
    int         nb     = 0;

    always #2.5 clk = ~clk;

    spi_status_guard i_spi_status_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .wp_n    (wp_n),
        .miso    (miso),
        .miso_oe (miso_oe),
        .status  (status)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift(input logic [23:0] d, input int n, input bit m3,
                         input bit hold, input bit hiz, input string tag);
        bit saw_oe = 0;
        sck = m3;
        wait_clk(3);
        cs_n = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < n; i++) begin
            if (m3) sck = 1'b0;
            mosi = d[23-i];
            wait_clk(HP);
            sck = 1'b1;
            wait_clk(HP);
            if (miso_oe) saw_oe = 1;
            if (!m3) sck = 1'b0;
        end
        if (hiz) chk(!saw_oe, {tag, " R8 output enable during shift"}, 8'(saw_oe), 8'h00);
        if (!hold) begin
            wait_clk(HP);
            cs_n = 1'b1;
            wait_clk(10);
        end
    endtask

    task automatic arm(input bit m3);
        shift({8'h50, 16'h0}, 8, m3, 0, 1, "arm");
    endtask

    task automatic wr(input logic [7:0] v, input bit m3);
        shift({8'h01, v, 8'h0}, 16, m3, 0, 1, "write");
    endtask

    task automatic rd(input logic [7:0] exp, input string tag, input bit m3, input int nbytes);
        for (int i = 0; i < nbytes; i++) sb_q.push_back('{val: exp, tag: tag});
        shift({8'h05, 16'h0}, 8 + 8 * nbytes, m3, 0, 0, "read");
    endtask

    // monitor: collects bytes from miso and compares against the scoreboard
    initial begin
        forever begin
            @(posedge sck or posedge cs_n);
            if (cs_n) begin
                nb = 0;
            end else if (miso_oe) begin
                rx = {rx[6:0], miso};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (sb_q.size() == 0) begin
                        chk(0, "scoreboard underflow", rx, 8'h00);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk(rx == e.val, e.tag, rx, e.val);
                    end
                end
            end
        end
    end

    initial begin
        wait_clk(100000);
        if (!done) begin
            done = 1;
            chk(0, "watchdog expired", 8'h00, 8'h00);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        chk(status == 8'h00, "R12 reset status", status, 8'h00);
        chk(miso_oe == 1'b0, "R12 reset output enable", 8'(miso_oe), 8'h00);
        rd(8'h00, "R12 reset read", 0, 1);

        wr(8'h8C, 0);
        rd(8'h00, "R2 write without arming", 0, 1);

        arm(0); wr(8'h0C, 0);
        rd(8'h0C, "R1 R6 armed write", 0, 1);

        arm(0); wr(8'hFF, 0);
        rd(8'h8C, "R12 unused bits read zero", 0, 1);

        arm(0); wr(8'h04, 0);
        rd(8'h04, "R6 clear lock with pin high", 0, 1);

        arm(0); shift({8'h06, 16'h0}, 8, 0, 0, 1, "other"); wr(8'h08, 0);
        rd(8'h04, "R2 intervening opcode cancels", 0, 1);

        arm(1); rd(8'h04, "R9 R13 read in mode 3", 1, 1); wr(8'h08, 1);
        rd(8'h08, "R10 R13 read keeps enable", 1, 1);

        shift({8'h50, 1'b0, 15'h0}, 9, 0, 0, 1, "long arm"); wr(8'h0C, 0);
        rd(8'h08, "R11 arm with 9 clocks", 0, 1);

        arm(0); shift({8'h01, 8'h0C, 8'h0}, 15, 0, 0, 1, "short write");
        rd(8'h08, "R11 write with 15 clocks", 0, 1);
        wr(8'h0C, 0);
        rd(8'h08, "R11 enable cleared by short write", 0, 1);

        arm(0); shift({8'h50, 16'h0}, 4, 0, 0, 1, "cut arm"); wr(8'h0C, 0);
        rd(8'h08, "R11 arm cut at 4 clocks", 0, 1);

        wp_n = 1'b0;
        wait_clk(10);
        arm(0);
        shift({8'h01, 8'h8C, 8'h0}, 16, 0, 1, 1, "held write");
        wait_clk(HP);
        chk(status == 8'h08, "R3 no change before chip-select rises", status, 8'h08);
        cs_n = 1'b1;
        wait_clk(10);
        chk(status == 8'h8C, "R3 R7 commit on chip-select rise", status, 8'h8C);
        rd(8'h8C, "R9 repeated byte", 0, 2);

        arm(0); wr(8'h00, 0);
        rd(8'h8C, "R5 lock cannot clear with pin low", 0, 1);
        arm(1); wr(8'h88, 1);
        rd(8'h8C, "R4 locked write ignored", 1, 1);

        wp_n = 1'b1;
        wait_clk(10);
        arm(0); wr(8'h00, 0);
        chk(status == 8'h00, "R6 unlock with pin high", status, 8'h00);
        rd(8'h00, "R6 unlock readback", 0, 1);

        wait_clk(20);
        chk(sb_q.size() == 0, "scoreboard drained", 8'(sb_q.size()), 8'h00);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule